// File: doc/BRIEF.md
# Encoding-Selectable Control State Machine

A four-state controller with the states idle, run, pause and done. A compile-time parameter sets the bit encoding of its state register: dense binary, one-hot or gray. The transition and output logic is written only against symbolic state names. Changing the parameter changes the register width and the bit patterns it holds. It does not change the sequence of decoded states.

The block exposes the raw register bits and one decoded flag per state. It also reports a register pattern that names no state, and it pulses a flag when an update flips more than one register bit. That flag shows where gray coding fails to give single-bit steps. Any pattern that names no state sends the machine back to idle on the next edge, so it cannot lock up. A load port writes an arbitrary value into the register, so that recovery can be exercised.

Top module: `fsm_enc_top`

## Requirements
- R1: With ENC=0 (binary) the register is 2 bits wide, holding idle=00, run=01, pause=10 and done=11.
- R2: With ENC=1 (one-hot) the register is 4 bits wide, holding idle=0001, run=0010, pause=0100 and done=1000.
- R3: With ENC=2 (gray) the register is 2 bits wide, holding idle=00, run=01, pause=11 and done=10.
- R4: While rst_n is low the register holds the idle code of the selected encoding, idle_o is high and multi_flip_o is low.
- R5: From idle, start_i moves to run. From pause, resume_i moves to run. Done always moves to idle on the next edge. In every other case the state holds.
- R6: In run, finish_i moves to done and takes priority over pause_i. pause_i alone moves to pause.
- R7: For a legal pattern exactly one of idle_o, run_o, pause_o and done_o is high. For an illegal pattern all four are low.
- R8: bad_code_o is high exactly when the register holds a pattern that names no state. In one-hot mode these are the patterns with zero or with several bits set. In binary and gray mode it is never high.
- R9: From an illegal pattern, the next edge without a load enters idle.
- R10: multi_flip_o is high in exactly those cycles in which the register value differs from its value one cycle earlier in more than one bit. This applies to loaded values too.
- R11: With load_en_i high, the next edge writes load_val_i into the register, ahead of any transition.
- R12: For identical input sequences without loads, the decoded flags are the same in every cycle for all three encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the user |
| start_i | input | 1 | Begin a run from idle |
| pause_i | input | 1 | Suspend a run |
| resume_i | input | 1 | Continue from pause |
| finish_i | input | 1 | End a run |
| load_en_i | input | 1 | Write load_val_i into the state register |
| load_val_i | input | SW | Value to be written (SW = 4 for one-hot, else 2) |
| state_bits_o | output | SW | Raw state register |
| idle_o | output | 1 | Decoded idle |
| run_o | output | 1 | Decoded run |
| pause_o | output | 1 | Decoded pause |
| done_o | output | 1 | Decoded done |
| bad_code_o | output | 1 | Register holds no legal state |
| multi_flip_o | output | 1 | Last update flipped more than one register bit |

## Verification
On every cycle the assertions check the exclusivity of the decoded flags and their silence on an illegal pattern. They also check the Hamming-distance meaning of multi_flip_o, recovery to idle, the done-to-idle step, the priority of finish over pause, and the load path. The exact bit pattern of each state under each encoding is checked only by the bench. So are the hold behaviour under idle inputs and the cycle-by-cycle equality of the decoded trace across the three encodings. The bench does this by running the three encodings side by side and by sweeping every loadable register value.

// File: rtl/fsm_enc_pkg.sv
package fsm_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  localparam int ENC_BIN  = 0;
  localparam int ENC_HOT  = 1;
  localparam int ENC_GRAY = 2;

  function automatic int reg_width(input int enc);
    return (enc == ENC_HOT) ? 4 : 2;
  endfunction
endpackage

// File: rtl/fsm_enc_encode.sv
module fsm_enc_encode
  import fsm_enc_pkg::*;
#(
  parameter int ENC = ENC_GRAY,
  parameter int SW  = reg_width(ENC)
) (
  input  state_e          sym_i,
  output logic [SW-1:0]   code_o
);
  if (ENC == ENC_HOT) begin : g_hot
    always_comb begin
      code_o = '0;
      case (sym_i)
        ST_IDLE:  code_o = SW'(4'b0001);
        ST_RUN:   code_o = SW'(4'b0010);
        ST_PAUSE: code_o = SW'(4'b0100);
        ST_DONE:  code_o = SW'(4'b1000);
        default:  code_o = SW'(4'b0001);
      endcase
    end
  end else if (ENC == ENC_GRAY) begin : g_gray
    always_comb begin
      code_o = '0;
      case (sym_i)
        ST_IDLE:  code_o = SW'(2'b00);
        ST_RUN:   code_o = SW'(2'b01);
        ST_PAUSE: code_o = SW'(2'b11);
        ST_DONE:  code_o = SW'(2'b10);
        default:  code_o = SW'(2'b00);
      endcase
    end
  end else begin : g_bin
    always_comb begin
      code_o = '0;
      case (sym_i)
        ST_IDLE:  code_o = SW'(2'b00);
        ST_RUN:   code_o = SW'(2'b01);
        ST_PAUSE: code_o = SW'(2'b10);
        ST_DONE:  code_o = SW'(2'b11);
        default:  code_o = SW'(2'b00);
      endcase
    end
  end
endmodule

// File: rtl/fsm_enc_decode.sv
module fsm_enc_decode
  import fsm_enc_pkg::*;
#(
  parameter int ENC = ENC_GRAY,
  parameter int SW  = reg_width(ENC)
) (
  input  logic [SW-1:0] code_i,
  output state_e        sym_o,
  output logic          legal_o
);
  if (ENC == ENC_HOT) begin : g_hot
    always_comb begin
      legal_o = 1'b1;
      sym_o   = ST_IDLE;
      case (code_i)
        SW'(4'b0001): sym_o = ST_IDLE;
        SW'(4'b0010): sym_o = ST_RUN;
        SW'(4'b0100): sym_o = ST_PAUSE;
        SW'(4'b1000): sym_o = ST_DONE;
        default:      legal_o = 1'b0;
      endcase
    end
  end else if (ENC == ENC_GRAY) begin : g_gray
    always_comb begin
      legal_o = 1'b1;
      sym_o   = ST_IDLE;
      case (code_i)
        SW'(2'b00): sym_o = ST_IDLE;
        SW'(2'b01): sym_o = ST_RUN;
        SW'(2'b11): sym_o = ST_PAUSE;
        SW'(2'b10): sym_o = ST_DONE;
        default:    legal_o = 1'b0;
      endcase
    end
  end else begin : g_bin
    always_comb begin
      legal_o = 1'b1;
      sym_o   = ST_IDLE;
      case (code_i)
        SW'(2'b00): sym_o = ST_IDLE;
        SW'(2'b01): sym_o = ST_RUN;
        SW'(2'b10): sym_o = ST_PAUSE;
        SW'(2'b11): sym_o = ST_DONE;
        default:    legal_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fsm_enc_next.sv
module fsm_enc_next
  import fsm_enc_pkg::*;
(
  input  state_e cur_i,
  input  logic   legal_i,
  input  logic   start_i,
  input  logic   pause_i,
  input  logic   resume_i,
  input  logic   finish_i,
  output state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!legal_i) begin
      nxt_o = ST_IDLE;
    end else begin
      case (cur_i)
        ST_IDLE:  if (start_i) nxt_o = ST_RUN;
        ST_RUN: begin
          if (finish_i)     nxt_o = ST_DONE;
          else if (pause_i) nxt_o = ST_PAUSE;
        end
        ST_PAUSE: if (resume_i) nxt_o = ST_RUN;
        ST_DONE:  nxt_o = ST_IDLE;
        default:  nxt_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsm_enc_top.sv
module fsm_enc_top
  import fsm_enc_pkg::*;
#(
  parameter int ENC = ENC_GRAY,
  localparam int SW = reg_width(ENC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pause_i,
  input  logic          resume_i,
  input  logic          finish_i,
  input  logic          load_en_i,
  input  logic [SW-1:0] load_val_i,
  output logic [SW-1:0] state_bits_o,
  output logic          idle_o,
  output logic          run_o,
  output logic          pause_o,
  output logic          done_o,
  output logic          bad_code_o,
  output logic          multi_flip_o
);
  state_e        cur_sym;
  state_e        nxt_sym;
  logic          cur_legal;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic [SW-1:0] nxt_code;
  logic [SW-1:0] idle_code;
  logic          flip_q;
  logic          flip_d;

  fsm_enc_decode #(.ENC(ENC), .SW(SW)) u_dec (
    .code_i (state_q),
    .sym_o  (cur_sym),
    .legal_o(cur_legal)
  );

  fsm_enc_next u_next (
    .cur_i   (cur_sym),
    .legal_i (cur_legal),
    .start_i (start_i),
    .pause_i (pause_i),
    .resume_i(resume_i),
    .finish_i(finish_i),
    .nxt_o   (nxt_sym)
  );

  fsm_enc_encode #(.ENC(ENC), .SW(SW)) u_enc (
    .sym_i (nxt_sym),
    .code_o(nxt_code)
  );

  fsm_enc_encode #(.ENC(ENC), .SW(SW)) u_enc_rst (
    .sym_i (ST_IDLE),
    .code_o(idle_code)
  );

  always_comb begin
    state_d = load_en_i ? load_val_i : nxt_code;
    flip_d  = ($countones(state_d ^ state_q) > 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= idle_code;
      flip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flip_q  <= flip_d;
    end
  end

  assign state_bits_o = state_q;
  assign idle_o       = cur_legal && (cur_sym == ST_IDLE);
  assign run_o        = cur_legal && (cur_sym == ST_RUN);
  assign pause_o      = cur_legal && (cur_sym == ST_PAUSE);
  assign done_o       = cur_legal && (cur_sym == ST_DONE);
  assign bad_code_o   = !cur_legal;
  assign multi_flip_o = flip_q;
endmodule

// File: rtl/fsm_enc_chk.sv
module fsm_enc_chk #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pause_i,
  input logic          finish_i,
  input logic          load_en_i,
  input logic [SW-1:0] load_val_i,
  input logic [SW-1:0] state_bits_o,
  input logic          idle_o,
  input logic          run_o,
  input logic          pause_o,
  input logic          done_o,
  input logic          bad_code_o,
  input logic          multi_flip_o
);
  logic [3:0] flags;
  assign flags = {done_o, pause_o, run_o, idle_o};

  AST_FLAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_code_o |-> ($countones(flags) == 1)); // R7
  AST_FLAGS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code_o |-> (flags == 4'b0000)); // R8
  AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_code_o && !load_en_i) |=> idle_o); // R9
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_en_i) |=> idle_o); // R5
  AST_FINISH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && finish_i && pause_i && !load_en_i) |=> done_o); // R6
  AST_FLIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    multi_flip_o |-> ($countones(state_bits_o ^ $past(state_bits_o)) > 1)); // R10
  AST_FLIP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_flip_o |-> ($countones(state_bits_o ^ $past(state_bits_o)) <= 1)); // R10
  AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> (state_bits_o == $past(load_val_i))); // R11
endmodule

bind fsm_enc_top fsm_enc_chk #(.SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pause_i     (pause_i),
  .finish_i    (finish_i),
  .load_en_i   (load_en_i),
  .load_val_i  (load_val_i),
  .state_bits_o(state_bits_o),
  .idle_o      (idle_o),
  .run_o       (run_o),
  .pause_o     (pause_o),
  .done_o      (done_o),
  .bad_code_o  (bad_code_o),
  .multi_flip_o(multi_flip_o)
);

// File: tb/tb_fsm_enc_top.sv
module tb_fsm_enc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NENC       = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start, pause, resume, finish, ld_en;
  logic [3:0] ld_val [NENC];
  logic [3:0] raw    [NENC];
  logic [3:0] flags  [NENC];
  logic       bad    [NENC];
  logic       flip   [NENC];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] mraw  [NENC];
  logic       mflip [NENC];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < NENC; k++) begin : g_enc
    localparam int W = (k == 1) ? 4 : 2;
    logic [W-1:0] bits;
    fsm_enc_top #(.ENC(k)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .pause_i     (pause),
      .resume_i    (resume),
      .finish_i    (finish),
      .load_en_i   (ld_en),
      .load_val_i  (ld_val[k][W-1:0]),
      .state_bits_o(bits),
      .idle_o      (flags[k][0]),
      .run_o       (flags[k][1]),
      .pause_o     (flags[k][2]),
      .done_o      (flags[k][3]),
      .bad_code_o  (bad[k]),
      .multi_flip_o(flip[k])
    );
    assign raw[k] = 4'(bits);
  end

  function automatic logic [3:0] mask(int k);
    return (k == 1) ? 4'hF : 4'h3;
  endfunction

  // symbolic index 0..3, 4 = no legal state
  function automatic int dec(int k, logic [3:0] v);
    if (k == 0) return int'(v[1:0]);
    if (k == 2) return int'({v[1], v[1] ^ v[0]});
    if ($countones(v) != 1) return 4;
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 4;
  endfunction

  function automatic logic [3:0] enc(int k, int s);
    logic [1:0] b = 2'(s);
    if (k == 1) return 4'b0001 << s;
    if (k == 2) return {2'b00, b ^ (b >> 1)};
    return {2'b00, b};
  endfunction

  function automatic int nxt(int s, logic st, logic pa, logic re, logic fi);
    case (s)
      0: return st ? 1 : 0;
      1: return fi ? 3 : (pa ? 2 : 1);
      2: return re ? 1 : 2;
      3: return 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int k, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s enc=%0d actual=%b expected=%b at %0t", req, k, act, exp, $time);
    end
  endtask

  task automatic check_all(string ctx);
    for (int k = 0; k < NENC; k++) begin
      int s = dec(k, mraw[k]);
      string rt = (k == 0) ? "R1" : ((k == 1) ? "R2" : "R3");
      chk({rt, " bits ", ctx}, k, raw[k] & mask(k), mraw[k]);
      chk({"R7 flags ", ctx}, k, flags[k], (s == 4) ? 4'b0000 : (4'b0001 << s));
      chk({"R8 bad ", ctx}, k, {3'b000, bad[k]}, {3'b000, s == 4});
      chk({"R10 flip ", ctx}, k, {3'b000, flip[k]}, {3'b000, mflip[k]});
    end
  endtask

  // drive at negedge, model the edge, sample at following negedge
  task automatic step(logic st, logic pa, logic re, logic fi, logic le, logic [3:0] lv, string ctx);
    start = st; pause = pa; resume = re; finish = fi; ld_en = le;
    for (int k = 0; k < NENC; k++) begin
      logic [3:0] n;
      ld_val[k] = lv & mask(k);
      n = le ? (lv & mask(k)) : enc(k, nxt(dec(k, mraw[k]), st, pa, re, fi));
      mflip[k] = ($countones(n ^ mraw[k]) > 1);
      mraw[k]  = n;
    end
    @(negedge clk);
    check_all(ctx);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 1'b0;
    start = 0; pause = 0; resume = 0; finish = 0; ld_en = 0;
    for (int k = 0; k < NENC; k++) begin
      ld_val[k] = 4'h0;
      mraw[k]   = enc(k, 0);
      mflip[k]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    check_all("R4 reset");
    rst_n = 1'b1;

    // directed walk: finish priority, holds, pause/resume
    step(0, 0, 0, 0, 0, 0, "R5 idle hold");
    step(1, 0, 0, 0, 0, 0, "R5 idle->run");
    step(0, 0, 0, 0, 0, 0, "R5 run hold");
    step(0, 1, 0, 0, 0, 0, "R6 run->pause");
    step(1, 1, 0, 1, 0, 0, "R5 pause hold");
    step(0, 0, 1, 0, 0, 0, "R5 pause->run");
    step(0, 1, 0, 1, 0, 0, "R6 finish wins");
    step(1, 1, 1, 1, 0, 0, "R5 done->idle");

    // long pseudo-random run, encodings compared against each other
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[1] & lfsr[6], lfsr[2], lfsr[3] & lfsr[7] & lfsr[9], 0, 0, "R5 R6 sweep");
      chk("R12 trace gray", 2, flags[2], flags[0]);
      chk("R12 trace hot", 1, flags[1], flags[0]);
    end

    // load every register value, then one free edge to recover or hold
    for (int p = 0; p < 16; p++) begin
      step(0, 0, 0, 0, 1, 4'(p), "R11 load");
      step(0, 0, 0, 0, 0, 0, "R9 recover");
    end
    step(0, 0, 0, 0, 1, 4'b0110, "R11 load two-hot");
    step(1, 1, 1, 1, 1, 4'b0000, "R11 load over inputs");
    step(1, 0, 0, 0, 0, 0, "R9 recover zero-hot");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule